// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine walks a ring of receive descriptors kept in a local descriptor memory. Each descriptor is four 32-bit words. Word 0 is the writeback word, which holds the frame length and the result flags. Word 1 is the control word, which holds hardware ownership and the interrupt request. Word 2 is the buffer address, which the engine carries and never reads. Word 3 is the size word, which holds the buffer size and the last-entry marker. Software fills the descriptors through a word-wide access port. Word address bits [1:0] select the word in a descriptor, and the upper bits select the descriptor index. Software places the ring so that the descriptor index alone addresses each entry, which is why the ring base sits on a 256-byte boundary.

A received-frame indication carries a byte length, CRC included, and eight result flags. The engine accepts it only when idle. It checks the current descriptor for hardware ownership. If the descriptor is owned, the engine writes the length and flags back, clears the ownership bit, raises the completion status when asked to, and steps to the next entry. If the descriptor is not owned, the engine drops the frame, raises a queue-empty status and stays on the same entry.

The control state machine has five states. IDLE accepts a frame on `frm_valid`. FETCH_CTL reads the control word. It goes to FETCH_SIZE when the descriptor is owned, or back to IDLE with the empty status when it is not. FETCH_SIZE reads the size word and goes to WB_STAT. WB_STAT writes word 0 and goes to WB_CTL. WB_CTL rewrites the control word, advances or wraps the index, and goes back to IDLE.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `ist` is 0, `irq` is 0, `frm_ready` is 1, and the first frame goes to descriptor 0.
- R2: A frame landing in an owned descriptor (control bit 31 = 1) gets word 0 written with the length in bits 15:0 and the flags in bits 23:16. The flag order from bit 16 upward is CRC-OK, collision, nibble error, overrun, MII error, too long, too short, abort. Bits 31:24 are 0.
- R3: After the writeback, control bit 31 reads 0 and all other control bits are unchanged.
- R4: When the current descriptor has control bit 31 = 0, no descriptor word changes, `ist` bit 7 is set, and the next frame is tried on the same descriptor.
- R5: A completed descriptor with control bit 30 = 1 sets `ist` bit 6. With control bit 30 = 0, `ist` bit 6 is left unchanged.
- R6: After a descriptor whose size word has bit 31 = 1, the next descriptor used is index 0. Otherwise it is the next index, and index NDESC-1 wraps to 0.
- R7: If the length exceeds the buffer size (size word bits 15:0), word 0 holds the buffer size as its length and has bit 21 (too long) set. A length equal to the buffer size is not clipped.
- R8: Writing `ist_wdata` with `ist_we` clears each `ist` bit that is 1 in the written value. An event that sets a bit in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some `ist` bit is set whose mask bit, written through `imask_we`, is also 1.
- R10: `frm_ready` falls in the cycle after a frame is accepted and stays low until the descriptor is finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Received-frame indication |
| frm_ready | output | 1 | Engine idle, frame accepted when valid |
| frm_len | input | 16 | Frame length in bytes, CRC included |
| frm_flags | input | 8 | Result flags, bit 0 = CRC-OK up to bit 7 = abort |
| sw_we | input | 1 | Software descriptor word write |
| sw_addr | input | AW | Software word address {index, word} |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Software read data, combinational |
| ist_we | input | 1 | Write-one-to-clear strobe for status |
| ist_wdata | input | 8 | Bits to clear |
| imask_we | input | 1 | Mask register write |
| imask_wdata | input | 8 | Mask value |
| ist | output | 8 | Status: bit 6 completion, bit 7 queue empty |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that software does not write a descriptor while `frm_ready` is low. Descriptor port writes from software lose to the engine's writes, so such a write could be dropped. They also assume that every wrap is marked or falls on index NDESC-1. The bench rearms each descriptor and clears the status only between frames, waiting until the engine is idle. Its ring setup always ends the ring on a valid index, so the index model in the bench stays consistent with the design.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_CTL,
        ST_FETCH_SIZE,
        ST_WB_STAT,
        ST_WB_CTL
    } rxr_state_t;

    localparam int WSEL_STAT = 0;
    localparam int WSEL_CTL  = 1;
    localparam int WSEL_SIZE = 3;

    localparam int CTL_OWN = 31;
    localparam int CTL_INT = 30;
    localparam int SZ_LAST = 31;

    localparam int FLG_LONG  = 5;
    localparam int IST_DONE  = 6;
    localparam int IST_EMPTY = 7;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [31:0]   a_wdata,
    output logic [31:0]   a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [31:0]   b_wdata,
    output logic [31:0]   b_rdata
);
    localparam int NW = 1 << AW;

    logic [31:0] words [NW];

    always_ff @(posedge clk) begin
        if (a_we)
            words[a_addr] <= a_wdata;
        else if (b_we)
            words[b_addr] <= b_wdata;
    end

    assign a_rdata = words[a_addr];
    assign b_rdata = words[b_addr];
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] set_vec,
    input  logic          clr_we,
    input  logic [SW-1:0] clr_vec,
    input  logic          mask_we,
    input  logic [SW-1:0] mask_wdata,
    output logic [SW-1:0] ist,
    output logic          irq
);
    logic [SW-1:0] mask_q;
    logic [SW-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_vec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ist    <= '0;
            mask_q <= '0;
        end else begin
            ist <= (ist & ~clr_eff) | set_vec;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    assign irq = |(ist & mask_q);
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_valid,
    input  logic [15:0]     frm_len,
    input  logic [7:0]      frm_flags,
    output logic            frm_ready,
    output logic [IDXW+1:0] mem_addr,
    output logic            mem_we,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic            done_p,
    output logic            empty_p,
    output logic            done_last,
    output logic            int_req,
    output logic [IDXW-1:0] cur_idx
);
    rxr_state_t state, nxt;

    logic [15:0]     len_q;
    logic [7:0]      flg_q;
    logic [31:0]     ctl_q;
    logic [15:0]     bsz_q;
    logic            last_q;
    logic            over;
    logic [15:0]     wb_len;
    logic [7:0]      wb_flg;
    logic [1:0]      wsel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (frm_valid) nxt = ST_FETCH_CTL;
            ST_FETCH_CTL:  nxt = mem_rdata[CTL_OWN] ? ST_FETCH_SIZE : ST_IDLE;
            ST_FETCH_SIZE: nxt = ST_WB_STAT;
            ST_WB_STAT:    nxt = ST_WB_CTL;
            ST_WB_CTL:     nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // captured frame and descriptor fields, ring index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q   <= '0;
            flg_q   <= '0;
            ctl_q   <= '0;
            bsz_q   <= '0;
            last_q  <= 1'b0;
            cur_idx <= '0;
        end else begin
            if (state == ST_IDLE && frm_valid) begin
                len_q <= frm_len;
                flg_q <= frm_flags;
            end
            if (state == ST_FETCH_CTL)
                ctl_q <= mem_rdata;
            if (state == ST_FETCH_SIZE) begin
                bsz_q  <= mem_rdata[15:0];
                last_q <= mem_rdata[SZ_LAST];
            end
            if (state == ST_WB_CTL)
                cur_idx <= last_q ? '0 : cur_idx + 1'b1;
        end
    end

    assign over   = len_q > bsz_q;
    assign wb_len = over ? bsz_q : len_q;
    assign wb_flg = flg_q | (over ? 8'(1 << FLG_LONG) : 8'h00);

    // outputs per state
    always_comb begin
        frm_ready = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        wsel      = 2'(WSEL_CTL);
        done_p    = 1'b0;
        empty_p   = 1'b0;
        done_last = 1'b0;
        int_req   = 1'b0;
        unique case (state)
            ST_IDLE:       frm_ready = 1'b1;
            ST_FETCH_CTL:  begin
                wsel    = 2'(WSEL_CTL);
                empty_p = ~mem_rdata[CTL_OWN];
            end
            ST_FETCH_SIZE: wsel = 2'(WSEL_SIZE);
            ST_WB_STAT:    begin
                wsel      = 2'(WSEL_STAT);
                mem_we    = 1'b1;
                mem_wdata = {8'h00, wb_flg, wb_len};
            end
            ST_WB_CTL:     begin
                wsel      = 2'(WSEL_CTL);
                mem_we    = 1'b1;
                mem_wdata = ctl_q & ~(32'd1 << CTL_OWN);
                done_p    = 1'b1;
                done_last = last_q;
                int_req   = ctl_q[CTL_INT];
            end
            default: ;
        endcase
        mem_addr = {cur_idx, wsel};
    end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int NDESC = 8,
    parameter int AW    = $clog2(NDESC) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_valid,
    output logic          frm_ready,
    input  logic [15:0]   frm_len,
    input  logic [7:0]    frm_flags,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_addr,
    input  logic [31:0]   sw_wdata,
    output logic [31:0]   sw_rdata,
    input  logic          ist_we,
    input  logic [7:0]    ist_wdata,
    input  logic          imask_we,
    input  logic [7:0]    imask_wdata,
    output logic [7:0]    ist,
    output logic          irq
);
    localparam int IDXW = AW - 2;

    logic [AW-1:0]   e_addr;
    logic            e_we;
    logic [31:0]     e_wdata;
    logic [31:0]     e_rdata;
    logic            done_p;
    logic            empty_p;
    logic            done_last;
    logic            int_req;
    logic [IDXW-1:0] cur_idx;
    logic [7:0]      set_vec;

    rxr_engine #(.IDXW(IDXW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_len   (frm_len),
        .frm_flags (frm_flags),
        .frm_ready (frm_ready),
        .mem_addr  (e_addr),
        .mem_we    (e_we),
        .mem_wdata (e_wdata),
        .mem_rdata (e_rdata),
        .done_p    (done_p),
        .empty_p   (empty_p),
        .done_last (done_last),
        .int_req   (int_req),
        .cur_idx   (cur_idx)
    );

    rxr_desc_mem #(.AW(AW)) u_mem (
        .clk     (clk),
        .a_we    (e_we),
        .a_addr  (e_addr),
        .a_wdata (e_wdata),
        .a_rdata (e_rdata),
        .b_we    (sw_we),
        .b_addr  (sw_addr),
        .b_wdata (sw_wdata),
        .b_rdata (sw_rdata)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[IST_DONE]  = done_p & int_req;
        set_vec[IST_EMPTY] = empty_p;
    end

    rxr_status #(.SW(8)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_we     (ist_we),
        .clr_vec    (ist_wdata),
        .mask_we    (imask_we),
        .mask_wdata (imask_wdata),
        .ist        (ist),
        .irq        (irq)
    );
endmodule

// File: rtl/rx_ring_checker.sv
module rx_ring_checker #(
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frm_valid,
    input logic            frm_ready,
    input logic            ist_we,
    input logic [7:0]      ist_wdata,
    input logic [7:0]      ist,
    input logic            irq,
    input logic            done_p,
    input logic            empty_p,
    input logic            done_last,
    input logic [IDXW-1:0] cur_idx
);
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && frm_ready |=> !frm_ready); // R10

    AST_EMPTY_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        empty_p |=> $stable(cur_idx)); // R4

    AST_EMPTY_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        empty_p |=> ist[7]); // R4

    AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        done_p && done_last |=> cur_idx == '0); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ist_we && ist_wdata[7] && !empty_p |=> !ist[7]); // R8

    AST_NO_IRQ_WITHOUT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ist == 8'h00 |-> !irq); // R9

    AST_SINGLE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_p, empty_p})); // R2
endmodule

bind rx_ring_engine rx_ring_checker #(.IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .frm_ready (frm_ready),
    .ist_we    (ist_we),
    .ist_wdata (ist_wdata),
    .ist       (ist),
    .irq       (irq),
    .done_p    (done_p),
    .empty_p   (empty_p),
    .done_last (done_last),
    .cur_idx   (cur_idx)
);

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;
    localparam int ND = 4;
    localparam int AW = 4;
    localparam logic [31:0] OWN = 32'h8000_0000;
    localparam logic [31:0] INTB = 32'h4000_0000;
    localparam logic [31:0] LAST = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0;
    logic frm_ready;
    logic [15:0] frm_len = '0;
    logic [7:0] frm_flags = '0;
    logic sw_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic ist_we = 1'b0;
    logic [7:0] ist_wdata = '0;
    logic imask_we = 1'b0;
    logic [7:0] imask_wdata = '0;
    logic [7:0] ist;
    logic irq;

    int tests = 0;
    int fails = 0;
    int eidx = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    rx_ring_engine #(.NDESC(ND)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int w, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = AW'(idx * 4 + w); sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic rdw(input int idx, input int w, output logic [31:0] d);
        @(negedge clk);
        sw_addr = AW'(idx * 4 + w);
        #1 d = sw_rdata;
    endtask

    task automatic clr_ist(input logic [7:0] v);
        @(negedge clk);
        ist_we = 1'b1; ist_wdata = v;
        @(negedge clk);
        ist_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] l, input logic [7:0] f);
        @(negedge clk);
        frm_valid = 1'b1; frm_len = l; frm_flags = f;
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R10 busy after accept", 32'(frm_ready), 32'd0);
        repeat (6) @(negedge clk);
        chk("R10 ready again", 32'(frm_ready), 32'd1);
    endtask

    function automatic logic [31:0] exp_wb(input int l, input int f, input int bsz);
        int el = (l > bsz) ? bsz : l;
        int ef = (l > bsz) ? (f | 32) : f;
        return {8'h00, 8'(ef), 16'(el)};
    endfunction

    initial begin : wdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ist reset", 32'(ist), 32'd0);
        chk("R1 irq reset", 32'(irq), 32'd0);
        chk("R1 ready reset", 32'(frm_ready), 32'd1);

        for (int i = 0; i < ND; i++) begin
            wr(i, 0, 32'hDEAD_0000 + i);
            wr(i, 1, OWN | INTB | 32'h0000_0123);
            wr(i, 2, 32'h1000_0000 + i * 256);
            wr(i, 3, 32'd1536);
        end

        // sweep: lengths and flag patterns, plain increment wrap at ND-1
        for (int n = 0; n < 10; n++) begin
            int l = 60 + n * 97;
            int f = (n * 37) & 8'hDF;
            send(16'(l), 8'(f));
            rdw(eidx, 0, rd); chk("R2 writeback word", rd, exp_wb(l, f, 1536));
            rdw(eidx, 1, rd); chk("R3 own cleared", rd, INTB | 32'h0000_0123);
            chk("R5 done status", 32'(ist[6]), 32'd1);
            clr_ist(8'h40);
            chk("R8 w1c clear", 32'(ist[6]), 32'd0);
            wr(eidx, 1, OWN | INTB | 32'h0000_0123);
            eidx = (eidx + 1) % ND; // R6 natural wrap
        end

        // R7: boundary on buffer size
        wr(eidx, 3, 32'd64);
        send(16'd64, 8'h01);
        rdw(eidx, 0, rd); chk("R7 equal not clipped", rd, exp_wb(64, 1, 64));
        wr(eidx, 1, OWN | INTB); wr(eidx, 3, 32'd1536);
        eidx = (eidx + 1) % ND;
        wr(eidx, 3, 32'd64);
        send(16'd100, 8'h01);
        rdw(eidx, 0, rd); chk("R7 too long clipped", rd, 32'h0021_0040);
        wr(eidx, 1, OWN | INTB); wr(eidx, 3, 32'd1536);
        eidx = (eidx + 1) % ND;
        clr_ist(8'hFF);

        // R4: not owned
        wr(eidx, 1, INTB);
        wr(eidx, 0, 32'h5A5A_5A5A);
        send(16'd80, 8'h01);
        rdw(eidx, 0, rd); chk("R4 no writeback", rd, 32'h5A5A_5A5A);
        rdw(eidx, 1, rd); chk("R4 ctl untouched", rd, INTB);
        chk("R4 empty status", 32'(ist), 32'h80);
        wr(eidx, 1, OWN);
        send(16'd90, 8'h03);
        rdw(eidx, 0, rd); chk("R4 same index retried", rd, exp_wb(90, 3, 1536));
        // R5: no interrupt request bit
        chk("R5 no done without int bit", 32'(ist[6]), 32'd0);
        wr(eidx, 1, OWN | INTB);
        eidx = (eidx + 1) % ND;
        clr_ist(8'hFF);

        // R6: last marker on an early entry
        wr(eidx, 3, LAST | 32'd1536);
        send(16'd70, 8'h01);
        wr(eidx, 1, OWN | INTB); wr(eidx, 3, 32'd1536);
        wr(0, 0, 32'h0);
        send(16'd71, 8'h05);
        rdw(0, 0, rd); chk("R6 wrap on last marker", rd, exp_wb(71, 5, 1536));
        wr(0, 1, OWN | INTB);

        // R9: mask
        chk("R9 irq masked", 32'(irq), 32'd0);
        @(negedge clk); imask_we = 1'b1; imask_wdata = 8'h40;
        @(negedge clk); imask_we = 1'b0;
        chk("R9 irq unmasked", 32'(irq), 32'd1);
        clr_ist(8'h40);
        chk("R9 irq after clear", 32'(irq), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule